// File: doc/BRIEF.md
# Byte-Pool FIFO with Watermarks

This block is a first-in first-out buffer for one direction of a serial controller. Its storage is a fixed pool of 256 bytes. Each entry is one byte, two bytes or four bytes wide, so a full buffer holds 256, 128 or 64 entries. Software sets it up with register writes on one select/data port. An operation write clears the buffer and starts or stops it. A control write sets the entry width and an 8-bit threshold. A watermark write sets three 6-bit occupancy marks.

The serial engine pushes and pops entries on the data side. A packed status word reports the level, full and empty at all times. Single-cycle event outputs tell an interrupt block when the threshold comparison flips, when the buffer becomes full or empty, and when a push was refused (overflow) or a pop was refused (underflow). Three watermark outputs compare the occupancy, counted in 4-byte units, with the stop, low and high marks.

The run control is a two-state machine. In state `ST_STOP` the buffer ignores traffic. In state `ST_RUN` it accepts traffic. The transition `ST_STOP -> ST_RUN` happens on an operation write with the start bit set. The transition `ST_RUN -> ST_STOP` happens on an operation write with the start bit clear.

Top module: `bpf_fifo`

## Requirements
- R1: After reset the block is in `ST_STOP` with width code 0 (byte), threshold 0 and all watermark marks 0. The status reads 0x200 (empty, level 0).
- R2: An operation write (reg_sel 0) with bit 0 set empties the buffer and clears both pointers. It also loads the pending width as the active width. Bit 1 of every operation write selects the next state: 1 gives `ST_RUN`, 0 gives `ST_STOP`.
- R3: In `ST_STOP`, push and pop have no effect on contents or status, and they raise no error.
- R4: Control bits 1:0 select the entry width: 0 is byte, 1 is halfword, 2 or 3 is 32-bit word. An entry is taken from the low bytes of push_data. Its lowest byte is stored first. pop_data shows the oldest entry, zero-extended.
- R5: A control write changes the pending width only in `ST_STOP`. The active width changes only at the next clear (R2).
- R6: Status bits 7:0 give the level in entries of the active width. Bit 8 is full and bit 9 is empty. A byte-wide buffer holding 256 entries reads full with level 0.
- R7: Entries leave in the order they arrived. A push and a pop in the same cycle both take effect when neither is refused.
- R8: A push in `ST_RUN` while full is refused. It raises ovf_err for exactly the next cycle.
- R9: A pop in `ST_RUN` while empty is refused. It raises udf_err for exactly the next cycle.
- R10: Control bits 9:2 hold the threshold. thd_evt is high for one cycle each time the result of (level >= threshold) differs from its value in the previous cycle.
- R11: full_evt is high for one cycle when the full flag rises. empty_evt is high for one cycle when the empty flag rises, and this includes a rise caused by a clear.
- R12: A watermark write (reg_sel 2) sets stop = bits 5:0, low = bits 15:10 and high = bits 25:20. With occupancy counted in 4-byte units, wm_stop = (occ == stop), wm_low = (occ < low) and wm_high = (occ > high).
- R13: A register write with reg_sel 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 operation, 1 control, 2 watermarks, 3 unused |
| reg_wdata | input | 32 | Register write data |
| push | input | 1 | Push one entry |
| push_data | input | 32 | Entry to push (low bytes used) |
| pop | input | 1 | Pop one entry |
| pop_data | output | 32 | Oldest entry, zero-extended |
| status | output | 10 | {empty, full, level[7:0]} |
| thd_evt | output | 1 | Threshold comparison changed |
| full_evt | output | 1 | Full flag rose |
| empty_evt | output | 1 | Empty flag rose |
| ovf_err | output | 1 | Refused push in previous cycle |
| udf_err | output | 1 | Refused pop in previous cycle |
| wm_stop | output | 1 | Occupancy equals the stop mark |
| wm_low | output | 1 | Occupancy below the low mark |
| wm_high | output | 1 | Occupancy above the high mark |

## Verification
The bench runs directed sequences first. These fill a byte-wide buffer past 256 entries and drain it past empty, which separates the full-with-level-zero encoding from a genuinely empty buffer. Width switches made while stopped and while running show whether the active width waits for a clear.

Random traffic then runs in each width, in push-heavy and pop-heavy phases, with stray control and watermark writes mixed in. This drives the threshold, full and empty edges in both directions. It also exposes any byte-lane or pointer-step error, because halfword and word entries move 2 or 4 bytes per operation.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

    typedef enum logic [1:0] {
        SEL_OP   = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_WM   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // width code -> log2 of bytes per entry
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/bpf_store.sv
module bpf_store #(
    parameter int POOL_BYTES = 256,
    parameter int DATA_W     = 32,
    localparam int AW        = $clog2(POOL_BYTES),
    localparam int CW        = AW + 1,
    localparam int LANES     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              do_push,
    input  logic              do_pop,
    input  logic [1:0]        shift,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     count
);

    logic [7:0]    mem [POOL_BYTES];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] nbytes;

    assign nbytes = CW'(1) << shift;

    always_ff @(posedge clk) begin
        if (do_push) begin
            for (int k = 0; k < LANES; k++) begin
                if (CW'(k) < nbytes)
                    mem[wptr + AW'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + nbytes[AW-1:0];
            if (do_pop)  rptr <= rptr + nbytes[AW-1:0];
            count <= count + (do_push ? nbytes : '0) - (do_pop ? nbytes : '0);
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++)
            pop_data[8*k +: 8] = (CW'(k) < nbytes) ? mem[rptr + AW'(k)] : 8'h00;
    end

    // R2: a clear leaves the pool empty
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    // R7: paired push and pop keep the occupancy
    a_r7_pair_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && do_pop && !clr) |=> $stable(count));
    // R6: occupancy never passes the pool size
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(POOL_BYTES));

endmodule

// File: rtl/bpf_ctrl.sv
module bpf_ctrl
    import bpf_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int THD_W  = 8,
    parameter int WM_W   = 6,
    localparam int THD_LSB = 2,
    localparam int LC_LSB  = 10,
    localparam int HC_LSB  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             push,
    input  logic             pop,
    input  logic             full,
    input  logic             empty,
    output logic             run,
    output logic             clr,
    output logic             do_push,
    output logic             do_pop,
    output logic [1:0]       shift,
    output logic [THD_W-1:0] thd,
    output logic [WM_W-1:0]  wm_stop_lvl,
    output logic [WM_W-1:0]  wm_low_lvl,
    output logic [WM_W-1:0]  wm_high_lvl
);

    run_state_e state, state_nxt;
    logic [1:0] width_pend, width_act;
    logic       op_wr, ctrl_wr, wm_wr;
    logic       unused_bits;

    assign op_wr   = reg_we && (reg_sel_e'(reg_sel) == SEL_OP);
    assign ctrl_wr = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign wm_wr   = reg_we && (reg_sel_e'(reg_sel) == SEL_WM);
    assign unused_bits = ^{reg_wdata[REG_W-1:HC_LSB+WM_W],
                           reg_wdata[HC_LSB-1:LC_LSB+WM_W]};

    // next-state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOP: if (op_wr &&  reg_wdata[1]) state_nxt = ST_RUN;
            ST_RUN:  if (op_wr && !reg_wdata[1]) state_nxt = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        run     = (state == ST_RUN);
        clr     = op_wr && reg_wdata[0];
        do_push = run && push && !full  && !clr;
        do_pop  = run && pop  && !empty && !clr;
        shift   = width_shift(width_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_pend  <= 2'd0;
            width_act   <= 2'd0;
            thd         <= '0;
            wm_stop_lvl <= '0;
            wm_low_lvl  <= '0;
            wm_high_lvl <= '0;
        end else begin
            if (clr) width_act <= width_pend;
            if (ctrl_wr) begin
                thd <= reg_wdata[THD_LSB +: THD_W];
                if (state == ST_STOP) width_pend <= reg_wdata[1:0];
            end
            if (wm_wr) begin
                wm_stop_lvl <= reg_wdata[0 +: WM_W];
                wm_low_lvl  <= reg_wdata[LC_LSB +: WM_W];
                wm_high_lvl <= reg_wdata[HC_LSB +: WM_W];
            end
        end
    end

    // R5: pending width frozen while running
    a_r5_width_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(width_pend));
    // R5: active width moves only on a clear
    a_r5_act_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(width_act));

endmodule

// File: rtl/bpf_monitor.sv
module bpf_monitor #(
    parameter int POOL_BYTES = 256,
    parameter int THD_W      = 8,
    parameter int WM_W       = 6,
    localparam int AW        = $clog2(POOL_BYTES),
    localparam int CW        = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    count,
    input  logic [1:0]       shift,
    input  logic [THD_W-1:0] thd,
    input  logic [WM_W-1:0]  wm_stop_lvl,
    input  logic [WM_W-1:0]  wm_low_lvl,
    input  logic [WM_W-1:0]  wm_high_lvl,
    input  logic             run,
    input  logic             push,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output logic [AW+1:0]    status,
    output logic             thd_evt,
    output logic             full_evt,
    output logic             empty_evt,
    output logic             ovf_err,
    output logic             udf_err,
    output logic             wm_stop,
    output logic             wm_low,
    output logic             wm_high
);

    logic [CW-1:0] entry_lvl, occ4;
    logic          reach, reach_q, full_q, empty_q;

    assign entry_lvl = count >> shift;
    assign occ4      = count >> 2;
    assign full      = (count == CW'(POOL_BYTES));
    assign empty     = (count == '0);
    assign reach     = (entry_lvl >= CW'(thd));
    assign status    = {empty, full, entry_lvl[AW-1:0]};

    assign thd_evt   = reach != reach_q;
    assign full_evt  = full && !full_q;
    assign empty_evt = empty && !empty_q;

    assign wm_stop   = (occ4 == CW'(wm_stop_lvl));
    assign wm_low    = (occ4 <  CW'(wm_low_lvl));
    assign wm_high   = (occ4 >  CW'(wm_high_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reach_q <= 1'b1;   // threshold resets to 0, so level >= thd
            full_q  <= 1'b0;
            empty_q <= 1'b1;
            ovf_err <= 1'b0;
            udf_err <= 1'b0;
        end else begin
            reach_q <= reach;
            full_q  <= full;
            empty_q <= empty;
            ovf_err <= run && push && full;
            udf_err <= run && pop && empty;
        end
    end

    // R6: full and empty never together
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty}));
    // R11: one edge event at a time
    a_r11_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full_evt, empty_evt}));
    // R8: overflow pulse lasts one cycle unless pushes keep hitting full
    a_r8_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> $past(full));

endmodule

// File: rtl/bpf_fifo.sv
module bpf_fifo
    import bpf_pkg::*;
#(
    parameter int POOL_BYTES = 256,
    parameter int DATA_W     = 32,
    parameter int REG_W      = 32,
    parameter int THD_W      = 8,
    parameter int WM_W       = 6,
    localparam int AW        = $clog2(POOL_BYTES),
    localparam int CW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [AW+1:0]     status,
    output logic              thd_evt,
    output logic              full_evt,
    output logic              empty_evt,
    output logic              ovf_err,
    output logic              udf_err,
    output logic              wm_stop,
    output logic              wm_low,
    output logic              wm_high
);

    logic             run, clr, do_push, do_pop, full, empty;
    logic [1:0]       shift;
    logic [THD_W-1:0] thd;
    logic [WM_W-1:0]  sc, lc, hc;
    logic [CW-1:0]    count;

    bpf_ctrl #(.REG_W(REG_W), .THD_W(THD_W), .WM_W(WM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .push(push), .pop(pop), .full(full),
        .empty(empty), .run(run), .clr(clr), .do_push(do_push),
        .do_pop(do_pop), .shift(shift), .thd(thd), .wm_stop_lvl(sc),
        .wm_low_lvl(lc), .wm_high_lvl(hc)
    );

    bpf_store #(.POOL_BYTES(POOL_BYTES), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .do_push(do_push),
        .do_pop(do_pop), .shift(shift), .push_data(push_data),
        .pop_data(pop_data), .count(count)
    );

    bpf_monitor #(.POOL_BYTES(POOL_BYTES), .THD_W(THD_W), .WM_W(WM_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .count(count), .shift(shift), .thd(thd),
        .wm_stop_lvl(sc), .wm_low_lvl(lc), .wm_high_lvl(hc), .run(run),
        .push(push), .pop(pop), .full(full), .empty(empty), .status(status),
        .thd_evt(thd_evt), .full_evt(full_evt), .empty_evt(empty_evt),
        .ovf_err(ovf_err), .udf_err(udf_err), .wm_stop(wm_stop),
        .wm_low(wm_low), .wm_high(wm_high)
    );

    // R3: stopped buffer keeps its occupancy
    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(count));

endmodule

// File: tb/tb_bpf_fifo.sv
module tb_bpf_fifo;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        push, pop;
    logic [31:0] push_data, pop_data;
    logic [9:0]  status;
    logic        thd_evt, full_evt, empty_evt, ovf_err, udf_err;
    logic        wm_stop, wm_low, wm_high;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    bpf_fifo dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .status(status), .thd_evt(thd_evt),
        .full_evt(full_evt), .empty_evt(empty_evt), .ovf_err(ovf_err),
        .udf_err(udf_err), .wm_stop(wm_stop), .wm_low(wm_low), .wm_high(wm_high)
    );

    // ---------------- reference model ----------------
    logic [7:0] mq[$];
    bit m_run, p_reach, p_full, p_empty, e_ovf, e_udf;
    int m_wpend, m_wact, m_thd, m_sc, m_lc, m_hc;

    function automatic int shf(int w);
        return (w == 0) ? 0 : (w == 1) ? 1 : 2;
    endfunction
    function automatic int m_lvl();
        return mq.size() >> shf(m_wact);
    endfunction
    function automatic bit m_full();
        return mq.size() == 256;
    endfunction
    function automatic bit m_empty();
        return mq.size() == 0;
    endfunction
    function automatic bit m_reach();
        return m_lvl() >= m_thd;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete();
            m_run = 0; m_wpend = 0; m_wact = 0; m_thd = 0;
            m_sc = 0; m_lc = 0; m_hc = 0;
            p_reach = 1; p_full = 0; p_empty = 1; e_ovf = 0; e_udf = 0;
        end else begin
            bit f0, em0, clr0, run0;
            int nb;
            f0 = m_full(); em0 = m_empty(); run0 = m_run;
            nb = 1 << shf(m_wact);
            p_reach = m_reach(); p_full = f0; p_empty = em0;
            e_ovf = run0 && push && f0;
            e_udf = run0 && pop && em0;
            clr0 = reg_we && reg_sel == 2'd0 && reg_wdata[0];
            if (!clr0 && run0) begin
                if (pop && !em0)
                    for (int k = 0; k < nb; k++) void'(mq.pop_front());
                if (push && !f0)
                    for (int k = 0; k < nb; k++) mq.push_back(push_data[8*k +: 8]);
            end
            if (reg_we) begin
                case (reg_sel)
                    2'd0: begin
                        if (reg_wdata[0]) begin mq.delete(); m_wact = m_wpend; end
                        m_run = reg_wdata[1];
                    end
                    2'd1: begin
                        m_thd = int'(reg_wdata[9:2]);
                        if (!run0) m_wpend = int'(reg_wdata[1:0]);
                    end
                    2'd2: begin
                        m_sc = int'(reg_wdata[5:0]);
                        m_lc = int'(reg_wdata[15:10]);
                        m_hc = int'(reg_wdata[25:20]);
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int occ, nb;
            logic [31:0] ed;
            occ = mq.size() >> 2;
            nb = 1 << shf(m_wact);
            chk("R6 status", {22'd0, status},
                {22'd0, m_empty(), m_full(), 8'(m_lvl())});
            chk("R10 thd_evt", {31'd0, thd_evt}, {31'd0, m_reach() != p_reach});
            chk("R11 full_evt", {31'd0, full_evt}, {31'd0, m_full() && !p_full});
            chk("R11 empty_evt", {31'd0, empty_evt}, {31'd0, m_empty() && !p_empty});
            chk("R8 ovf_err", {31'd0, ovf_err}, {31'd0, e_ovf});
            chk("R9 udf_err", {31'd0, udf_err}, {31'd0, e_udf});
            chk("R12 wm", {29'd0, wm_stop, wm_low, wm_high},
                {29'd0, occ == m_sc, occ < m_lc, occ > m_hc});
            if (!m_empty()) begin
                ed = '0;
                for (int k = 0; k < nb; k++) ed[8*k +: 8] = mq[k];
                chk("R7 pop_data", pop_data, ed);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit we, input logic [1:0] sel, input logic [31:0] d,
                         input bit ps, input logic [31:0] pd, input bit pp);
        reg_we = we; reg_sel = sel; reg_wdata = d;
        push = ps; push_data = pd; pop = pp;
        @(posedge clk); #1;
        reg_we = 0; push = 0; pop = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        drive(1'b1, sel, d, 1'b0, '0, 1'b0);
    endtask

    initial begin
        rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
        push = 0; pop = 0; push_data = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", {22'd0, status}, 32'h200);
        chk("R1 reset watermarks", {29'd0, wm_stop, wm_low, wm_high}, 32'h4);

        // R13 / R3: unused select and stopped traffic
        wr(2'd3, 32'h3);
        drive(0, 0, 0, 1, 32'h55, 0);
        drive(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R13 sel3 write ignored", {22'd0, status}, 32'h200);
        chk("R3 stopped no error", {30'd0, ovf_err, udf_err}, 32'h0);

        // byte mode, thd=2
        wr(2'd1, 32'd2 << 2);
        wr(2'd0, 32'h3);
        drive(0, 0, 0, 1, 32'h11, 0);
        drive(0, 0, 0, 1, 32'h22, 0);
        @(negedge clk);
        chk("R10 thd crossing up", {31'd0, thd_evt}, 32'h1);
        chk("R7 oldest shown", pop_data, 32'h11);
        drive(0, 0, 0, 1, 32'h33, 1);
        @(negedge clk);
        chk("R7 push+pop level", {22'd0, status}, 32'h002);
        for (int i = 0; i < 260; i++) drive(0, 0, 0, 1, i, 0);
        @(negedge clk);
        chk("R6 full byte level 0", {22'd0, status}, 32'h100);
        for (int i = 0; i < 258; i++) drive(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R9 drained empty", {22'd0, status}, 32'h200);

        // R2: clear while holding data
        drive(0, 0, 0, 1, 32'h9, 0);
        wr(2'd0, 32'h3);
        @(negedge clk);
        chk("R2 clear empties", {22'd0, status}, 32'h200);

        // R3: stop then traffic
        wr(2'd0, 32'h0);
        drive(0, 0, 0, 1, 32'h77, 0);
        @(negedge clk);
        chk("R3 stopped push ignored", {22'd0, status}, 32'h200);

        // R4 halfword
        wr(2'd1, 32'h1);
        wr(2'd0, 32'h3);
        drive(0, 0, 0, 1, 32'hAABBCCDD, 0);
        @(negedge clk);
        chk("R4 halfword entry", pop_data, 32'h0000CCDD);

        // R5: width write while running is ignored
        wr(2'd1, 32'h2);
        wr(2'd0, 32'h3);
        drive(0, 0, 0, 1, 32'h12345678, 0);
        @(negedge clk);
        chk("R5 width kept halfword", pop_data, 32'h00005678);

        // R5/R2: width set while stopped, takes effect at clear
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h2);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h2);
        wr(2'd2, 32'd5 | (32'd8 << 10) | (32'd10 << 20));
        for (int i = 0; i < 66; i++) drive(0, 0, 0, 1, 32'hC0DE0000 + i, 0);
        @(negedge clk);
        chk("R4 word full level 64", {22'd0, status}, 32'h140);
        chk("R12 high mark", {29'd0, wm_stop, wm_low, wm_high}, 32'h1);
        chk("R4 word entry", pop_data, 32'hC0DE0000);

        // random phases per width
        for (int w = 0; w < 3; w++) begin
            wr(2'd0, 32'h0);
            wr(2'd1, ($urandom_range(0, 255) << 2) | w);
            wr(2'd0, 32'h3);
            for (int ph = 0; ph < 4; ph++) begin
                for (int c = 0; c < 700; c++) begin
                    int r;
                    bit ps, pp;
                    r = $urandom_range(0, 99);
                    ps = (ph % 2 == 0) ? (r < 85) : (r < 15);
                    pp = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 15 : 85));
                    if ($urandom_range(0, 99) == 0)
                        drive(1, ($urandom_range(0, 1) != 0) ? 2'd2 : 2'd1,
                              $urandom, ps, $urandom, pp);
                    else
                        drive(0, 0, 0, ps, $urandom, pp);
                end
            end
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule